// File: doc/BRIEF.md
# DDR SDRAM Bank State Tracker

This block watches the command pins of a DDR SDRAM interface on every rising clock edge. It decodes the chip-select, row-strobe, column-strobe and write-enable levels into a command, then keeps one state machine for each bank. Each bank follows the full row life cycle: opening, open, reading, writing, write recovery, closing and refresh. Both the plain and the auto-precharge variants of read and write are tracked.

States that last a fixed time load a down-counter from a parameter and move on when the counter runs out. A command that the current bank states do not allow is rejected. It raises a one-cycle flag and changes no bank state, while every running countdown carries on as if the cycle had been a NOP.

A memory controller model or a protocol monitor instantiates the block next to the pins. It reads the packed state vector and the flag. Burst length, CAS latency and the timing counts are elaboration parameters.

Top module: `ddr_bank_tracker`

## Requirements
- R1: After reset every bank reports IDLE (code 0) and `illegal` is low. State codes are 4 bits per bank, with bank i at `bank_state[4i+3:4i]`: IDLE 0, ACTIVATING 1, ACTIVE 2, READ 3, READ_AP 4, WRITE 5, WRITE_AP 6, WRITE_REC 7, PRECHARGING 8, REFRESH 9.
- R2: An activate (cs_n,ras_n,cas_n,we_n = 0,0,1,1) to an IDLE bank makes it ACTIVATING for T_RCD cycles, then ACTIVE.
- R3: A read (0,1,0,1) to an ACTIVE or READ bank makes it READ for BURST_LEN/2+CAS_LAT cycles, then ACTIVE. With a10 high it goes to READ_AP for the same time, then to PRECHARGING.
- R4: A write (0,1,0,0) with a10 low to an ACTIVE, WRITE or WRITE_REC bank makes it WRITE for 1+BURST_LEN/2 cycles, then WRITE_REC for T_WR cycles, then ACTIVE.
- R5: A write with a10 high makes the bank WRITE_AP for 1+BURST_LEN/2+T_WR cycles, then PRECHARGING.
- R6: A precharge (0,0,1,0) with a10 low affects only the addressed bank. It is accepted in IDLE, PRECHARGING, ACTIVE and READ. From ACTIVE or READ the bank becomes PRECHARGING for T_RP cycles, then IDLE; in IDLE or PRECHARGING it has no effect. With a10 high it applies to every bank, and it is illegal if any bank is outside those four states.
- R7: An auto-refresh (0,0,0,1) is legal only when every bank is IDLE. All banks then report REFRESH for T_RFC cycles and return to IDLE. While banks are refreshing, every command other than NOP and deselect is illegal.
- R8: In READ_AP or WRITE_AP, a burst stop (0,1,1,0), read, write, activate or precharge to that bank is illegal; NOP is accepted.
- R9: A write to a bank in READ is illegal. A burst stop to a bank in READ returns it to ACTIVE in the next cycle.
- R10: `illegal` is high in exactly the cycle after a rejected command. A rejected command changes no bank state, and running countdowns continue. A read is legal only in ACTIVE or READ, and an activate only in IDLE.
- R11: With cs_n high the other pins are ignored. A command to one bank leaves the other banks unchanged.
- R12: A mode-register command (0,0,0,0) is legal only when every bank is IDLE, and it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, pins sampled on rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Auto-precharge / precharge-all select |
| bank_state | output | 4*NUM_BANKS | Packed per-bank state codes |
| illegal | output | 1 | Rejected-command pulse |

## Verification
The case that needs care is a rejected command arriving in a cycle where the bank's own countdown is still running. The flag must rise, and the timed state must still end on the cycle its countdown sets. The bench provokes this in several ways: a write, read, activate, precharge or burst stop is sent into a READ, READ_AP or WRITE_AP interval, and an activate is sent while all banks are refreshing. It then counts the samples each state lasts against the nominal length. It also checks that the flag drops on the following NOP.

// File: rtl/ddr_trk_pkg.sv
package ddr_trk_pkg;

   typedef enum logic [3:0] {
      BK_IDLE = 4'd0,
      BK_ACTG = 4'd1,
      BK_ACTV = 4'd2,
      BK_RD   = 4'd3,
      BK_RDAP = 4'd4,
      BK_WR   = 4'd5,
      BK_WRAP = 4'd6,
      BK_WREC = 4'd7,
      BK_PCHG = 4'd8,
      BK_RFSH = 4'd9
   } bank_st_e;

   typedef enum logic [3:0] {
      C_DESL, C_NOP, C_BST, C_RD, C_WR, C_ACT, C_PRE, C_REF, C_MRS
   } cmd_e;

   // states in which a single-bank precharge is accepted
   function automatic logic pre_ok(input bank_st_e s);
      return (s == BK_IDLE) || (s == BK_PCHG) || (s == BK_ACTV) || (s == BK_RD);
   endfunction

endpackage

// File: rtl/ddr_cmd_decode.sv
module ddr_cmd_decode
   import ddr_trk_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   output cmd_e cmd
);

   always_comb begin
      if (cs_n) begin
         cmd = C_DESL;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b111:  cmd = C_NOP;
            3'b110:  cmd = C_BST;
            3'b101:  cmd = C_RD;
            3'b100:  cmd = C_WR;
            3'b011:  cmd = C_ACT;
            3'b010:  cmd = C_PRE;
            3'b001:  cmd = C_REF;
            default: cmd = C_MRS;
         endcase
      end
   end

endmodule

// File: rtl/ddr_cmd_check.sv
module ddr_cmd_check
   import ddr_trk_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BA_W      = 2
) (
   input  cmd_e            cmd,
   input  logic [BA_W-1:0] ba,
   input  logic            a10,
   input  bank_st_e        st [NUM_BANKS],
   output logic            reject
);

   logic     any_rfsh, all_idle, all_pre_ok;
   bank_st_e tgt;

   always_comb begin
      any_rfsh   = 1'b0;
      all_idle   = 1'b1;
      all_pre_ok = 1'b1;
      for (int i = 0; i < NUM_BANKS; i++) begin
         any_rfsh   = any_rfsh | (st[i] == BK_RFSH);
         all_idle   = all_idle & (st[i] == BK_IDLE);
         all_pre_ok = all_pre_ok & pre_ok(st[i]);
      end
   end

   assign tgt = st[ba];

   always_comb begin
      reject = 1'b0;
      if (cmd != C_DESL && cmd != C_NOP && any_rfsh) begin
         reject = 1'b1;
      end else begin
         case (cmd)
            C_BST:   reject = (tgt == BK_RDAP) || (tgt == BK_WRAP);
            C_RD:    reject = !((tgt == BK_ACTV) || (tgt == BK_RD));
            C_WR:    reject = !((tgt == BK_ACTV) || (tgt == BK_WR) || (tgt == BK_WREC));
            C_ACT:   reject = (tgt != BK_IDLE);
            C_PRE:   reject = a10 ? !all_pre_ok : !pre_ok(tgt);
            C_REF,
            C_MRS:   reject = !all_idle;
            default: reject = 1'b0;
         endcase
      end
   end

endmodule

// File: rtl/ddr_bank_fsm.sv
module ddr_bank_fsm
   import ddr_trk_pkg::*;
#(
   parameter int T_RCD  = 3,
   parameter int T_RP   = 3,
   parameter int T_RFC  = 10,
   parameter int T_WR   = 2,
   parameter int RD_LEN = 4,
   parameter int WR_LEN = 3,
   parameter int CNT_W  = 4
) (
   input  logic     clk,
   input  logic     rst_n,
   input  cmd_e     cmd,     // already filtered: rejected commands arrive as NOP
   input  logic     hit,
   input  logic     a10,
   output bank_st_e st
);

   localparam logic [CNT_W-1:0] LD_RCD  = CNT_W'(T_RCD - 1);
   localparam logic [CNT_W-1:0] LD_RP   = CNT_W'(T_RP - 1);
   localparam logic [CNT_W-1:0] LD_RFC  = CNT_W'(T_RFC - 1);
   localparam logic [CNT_W-1:0] LD_WR   = CNT_W'(T_WR - 1);
   localparam logic [CNT_W-1:0] LD_RD   = CNT_W'(RD_LEN - 1);
   localparam logic [CNT_W-1:0] LD_WB   = CNT_W'(WR_LEN - 1);
   localparam logic [CNT_W-1:0] LD_WAP  = CNT_W'(WR_LEN + T_WR - 1);

   bank_st_e         st_n;
   logic [CNT_W-1:0] cnt, cnt_n;
   logic             started, timed;

   assign timed = (st != BK_IDLE) && (st != BK_ACTV);

   always_comb begin
      st_n    = st;
      cnt_n   = cnt;
      started = 1'b0;
      if (hit) begin
         case (cmd)
            C_ACT: begin st_n = BK_ACTG; cnt_n = LD_RCD; started = 1'b1; end
            C_RD: begin
               st_n = a10 ? BK_RDAP : BK_RD; cnt_n = LD_RD; started = 1'b1;
            end
            C_WR: begin
               st_n    = a10 ? BK_WRAP : BK_WR;
               cnt_n   = a10 ? LD_WAP : LD_WB;
               started = 1'b1;
            end
            C_BST: if (st == BK_RD) begin st_n = BK_ACTV; started = 1'b1; end
            C_PRE: if (st != BK_IDLE && st != BK_PCHG) begin
               st_n = BK_PCHG; cnt_n = LD_RP; started = 1'b1;
            end
            C_REF: begin st_n = BK_RFSH; cnt_n = LD_RFC; started = 1'b1; end
            default: ;
         endcase
      end
      if (!started && timed) begin
         if (cnt == '0) begin
            case (st)
               BK_ACTG, BK_RD, BK_WREC: st_n = BK_ACTV;
               BK_RDAP, BK_WRAP: begin st_n = BK_PCHG; cnt_n = LD_RP; end
               BK_WR:   begin st_n = BK_WREC; cnt_n = LD_WR; end
               default: st_n = BK_IDLE;
            endcase
         end else begin
            cnt_n = cnt - 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= BK_IDLE;
         cnt <= '0;
      end else begin
         st  <= st_n;
         cnt <= cnt_n;
      end
   end

   p_act_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BK_ACTG && $past(st) != BK_ACTG) |-> $past(st) == BK_IDLE);

   p_wap_to_pchg_r5: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(st) == BK_WRAP && st != BK_WRAP) |-> st == BK_PCHG);

   p_idle_entry_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BK_IDLE && $past(st) != BK_IDLE) |->
         ($past(st) == BK_PCHG || $past(st) == BK_RFSH));

   p_rfsh_from_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st == BK_RFSH && $past(st) != BK_RFSH) |-> $past(st) == BK_IDLE);

endmodule

// File: rtl/ddr_bank_tracker.sv
module ddr_bank_tracker
   import ddr_trk_pkg::*;
#(
   parameter int NUM_BANKS = 4,
   parameter int BURST_LEN = 4,
   parameter int CAS_LAT   = 2,
   parameter int T_RCD     = 3,
   parameter int T_RP      = 3,
   parameter int T_RFC     = 10,
   parameter int T_WR      = 2,
   localparam int BA_W     = $clog2(NUM_BANKS)
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cs_n,
   input  logic                   ras_n,
   input  logic                   cas_n,
   input  logic                   we_n,
   input  logic [BA_W-1:0]        ba,
   input  logic                   a10,
   output logic [4*NUM_BANKS-1:0] bank_state,
   output logic                   illegal
);

   localparam int RD_LEN = BURST_LEN / 2 + CAS_LAT;
   localparam int WR_LEN = 1 + BURST_LEN / 2;
   localparam int M1     = (T_RCD > T_RP) ? T_RCD : T_RP;
   localparam int M2     = (M1 > T_RFC) ? M1 : T_RFC;
   localparam int M3     = (M2 > RD_LEN) ? M2 : RD_LEN;
   localparam int MAX_T  = (M3 > WR_LEN + T_WR) ? M3 : WR_LEN + T_WR;
   localparam int CNT_W  = $clog2(MAX_T + 1);

   initial begin : elab_chk
      assert (NUM_BANKS >= 2 && NUM_BANKS == (1 << BA_W))
         else $error("NUM_BANKS must be a power of two, at least 2");
      assert (BURST_LEN >= 2 && BURST_LEN % 2 == 0)
         else $error("BURST_LEN must be even");
      assert (CAS_LAT >= 1 && T_RCD >= 1 && T_RP >= 1 && T_RFC >= 1 && T_WR >= 1)
         else $error("timing counts must be at least 1");
   end

   cmd_e     cmd, cmd_eff;
   logic     reject, illegal_q;
   bank_st_e st [NUM_BANKS];

   ddr_cmd_decode u_dec (
      .cs_n (cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .cmd(cmd)
   );

   ddr_cmd_check #(.NUM_BANKS(NUM_BANKS), .BA_W(BA_W)) u_chk (
      .cmd(cmd), .ba(ba), .a10(a10), .st(st), .reject(reject)
   );

   assign cmd_eff = reject ? C_NOP : cmd;

   for (genvar i = 0; i < NUM_BANKS; i++) begin : g_bank
      logic hit;
      assign hit = (ba == BA_W'(i)) || (cmd_eff == C_PRE && a10) || (cmd_eff == C_REF);

      ddr_bank_fsm #(
         .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC), .T_WR(T_WR),
         .RD_LEN(RD_LEN), .WR_LEN(WR_LEN), .CNT_W(CNT_W)
      ) u_fsm (
         .clk(clk), .rst_n(rst_n), .cmd(cmd_eff), .hit(hit), .a10(a10), .st(st[i])
      );

      assign bank_state[4*i +: 4] = st[i];

      p_rfsh_lockstep_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (st[i] == BK_RFSH) |-> (st[0] == BK_RFSH));

      p_reject_starts_nothing_r10: assert property (@(posedge clk) disable iff (!rst_n)
         illegal_q |-> !(st[i] == BK_ACTG && $past(st[i]) == BK_IDLE));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) illegal_q <= 1'b0;
      else        illegal_q <= reject;
   end

   assign illegal = illegal_q;

endmodule

// File: tb/ddr_bank_tracker_tb.sv
module ddr_bank_tracker_tb;

   localparam int NB = 4;
   localparam logic [3:0] P_NOP = 4'b0111, P_BST = 4'b0110, P_RD = 4'b0101,
                          P_WR = 4'b0100, P_ACT = 4'b0011, P_PRE = 4'b0010,
                          P_REF = 4'b0001, P_MRS = 4'b0000, P_DES = 4'b1011;
   localparam int ALL = -2, NONE = -1;

   typedef struct {
      int    bank;
      int    code;
      logic  ill;
      string tag;
   } exp_t;

   logic            clk = 1'b0, rst_n = 1'b0;
   logic            cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
   logic [1:0]      ba = '0;
   logic [4*NB-1:0] bank_state;
   logic            illegal;
   int              checks = 0, errors = 0;
   exp_t            q [$];

   always #2 clk = ~clk;

   ddr_bank_tracker u_dut (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
      .we_n(we_n), .ba(ba), .a10(a10), .bank_state(bank_state), .illegal(illegal)
   );

   // driver: one command per cycle plus the expected result after its edge
   task automatic cyc(input logic [3:0] p, input int b, input logic a,
                      input int cb, input int code, input logic il, input string tag);
      exp_t e;
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = p;
      ba  = 2'(b);
      a10 = a;
      e.bank = cb; e.code = code; e.ill = il; e.tag = tag;
      q.push_back(e);
   endtask

   task automatic nops(input int n, input int cb, input int code, input string tag);
      for (int k = 0; k < n; k++) cyc(P_NOP, 0, 1'b0, cb, code, 1'b0, tag);
   endtask

   // monitor: samples 1 ns after the edge that consumed the item
   always begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         checks++;
         if (illegal !== e.ill) begin
            errors++;
            $display("FAIL %s illegal got %0b exp %0b", e.tag, illegal, e.ill);
         end
         for (int i = 0; i < NB; i++) begin
            if ((e.bank == ALL || e.bank == i) && bank_state[4*i +: 4] !== 4'(e.code)) begin
               errors++;
               $display("FAIL %s bank %0d state got %0d exp %0d",
                        e.tag, i, bank_state[4*i +: 4], e.code);
            end
         end
      end
   end

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      cyc(P_NOP, 0, 0, ALL, 0, 0, "R1 reset");
      // R2 activate timing
      cyc(P_ACT, 0, 0, 0, 1, 0, "R2 act");
      nops(2, 0, 1, "R2 activating");
      cyc(P_NOP, 0, 0, 0, 2, 0, "R2 active");
      cyc(P_NOP, 0, 0, 1, 0, 0, "R11 other bank idle");
      // R3 plain read
      cyc(P_RD, 0, 0, 0, 3, 0, "R3 read");
      nops(3, 0, 3, "R3 read hold");
      cyc(P_NOP, 0, 0, 0, 2, 0, "R3 read end");
      // R9 write into read rejected, burst stop ends read
      cyc(P_RD, 0, 0, 0, 3, 0, "R9 read");
      cyc(P_WR, 0, 0, 0, 3, 1, "R9 write in read");
      cyc(P_BST, 0, 0, 0, 2, 0, "R9 burst stop");
      // R4 plain write
      cyc(P_WR, 0, 0, 0, 5, 0, "R4 write");
      nops(2, 0, 5, "R4 write hold");
      nops(2, 0, 7, "R4 recovery");
      cyc(P_NOP, 0, 0, 0, 2, 0, "R4 back active");
      // R3 read with auto-precharge, R8 burst stop rejected
      cyc(P_RD, 0, 1, 0, 4, 0, "R3 read ap");
      cyc(P_BST, 0, 0, 0, 4, 1, "R8 bst in read ap");
      nops(2, 0, 4, "R3 read ap hold");
      nops(3, 0, 8, "R3 auto precharge");
      cyc(P_NOP, 0, 0, 0, 0, 0, "R6 idle after precharge");
      // R5 write with auto-precharge, R8 rejections
      cyc(P_ACT, 1, 0, 1, 1, 0, "R2 act b1");
      nops(2, 1, 1, "R2 activating b1");
      cyc(P_NOP, 0, 0, 1, 2, 0, "R2 active b1");
      cyc(P_WR, 1, 1, 1, 6, 0, "R5 write ap");
      cyc(P_RD, 1, 0, 1, 6, 1, "R8 read in write ap");
      cyc(P_ACT, 1, 0, 1, 6, 1, "R8 act in write ap");
      cyc(P_PRE, 1, 0, 1, 6, 1, "R8 pre in write ap");
      cyc(P_NOP, 0, 0, 1, 6, 0, "R10 pulse drops");
      nops(3, 1, 8, "R5 auto precharge");
      cyc(P_NOP, 0, 0, 1, 0, 0, "R5 idle");
      cyc(P_NOP, 0, 0, 0, 0, 0, "R11 bank0 untouched");
      // R6 precharge all
      cyc(P_ACT, 1, 0, 1, 1, 0, "R2 act b1");
      nops(2, 1, 1, "R2 activating b1");
      cyc(P_ACT, 2, 0, 1, 2, 0, "R2 act b2");
      cyc(P_PRE, 0, 1, 2, 1, 1, "R6 pall with activating bank");
      cyc(P_NOP, 0, 0, 2, 1, 0, "R10 timer continues");
      cyc(P_NOP, 0, 0, 2, 2, 0, "R10 timer ends on time");
      cyc(P_PRE, 3, 1, 1, 8, 0, "R6 pall b1");
      cyc(P_NOP, 0, 0, 0, 0, 0, "R6 pall idle bank stays");
      cyc(P_NOP, 0, 0, 2, 8, 0, "R6 pall b2");
      cyc(P_NOP, 0, 0, ALL, 0, 0, "R6 all idle");
      cyc(P_PRE, 3, 0, 3, 0, 0, "R6 pre in idle");
      // R7 refresh
      cyc(P_REF, 0, 0, ALL, 9, 0, "R7 refresh");
      cyc(P_ACT, 0, 0, ALL, 9, 1, "R7 act in refresh");
      nops(8, ALL, 9, "R7 refresh hold");
      cyc(P_NOP, 0, 0, ALL, 0, 0, "R7 refresh end");
      cyc(P_ACT, 0, 0, 0, 1, 0, "R2 act");
      cyc(P_REF, 0, 0, 0, 1, 1, "R7 refresh not idle");
      cyc(P_NOP, 0, 0, 0, 1, 0, "R10 activating kept");
      cyc(P_NOP, 0, 0, 0, 2, 0, "R2 active");
      cyc(P_ACT, 0, 0, 0, 2, 1, "R10 act in active");
      cyc(P_RD, 3, 0, 3, 0, 1, "R10 read in idle");
      // R12 mode register
      cyc(P_MRS, 0, 0, 0, 2, 1, "R12 mrs not idle");
      cyc(P_PRE, 0, 0, 0, 8, 0, "R6 pre b0");
      nops(2, 0, 8, "R6 precharging");
      cyc(P_NOP, 0, 0, 0, 0, 0, "R6 idle");
      cyc(P_MRS, 0, 0, ALL, 0, 0, "R12 mrs idle");
      // R11 deselect ignores pins
      cyc(P_DES, 2, 0, ALL, 0, 0, "R11 deselect");
      cyc(P_NOP, 0, 0, NONE, 0, 0, "R11 deselect no flag");
      repeat (3) @(negedge clk);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule